// File: doc/BRIEF.md
# Max-Log Trellis State-Metric Unit

This block performs the state-metric recursions of a soft-input soft-output decoder for an 8-state binary convolutional code. The code's recursive systematic encoder has feedback polynomial 1+D^2+D^3 and feed-forward polynomial 1+D+D^3. Each recursion uses the max-log approximation. A trellis step takes three signed soft values: the a-priori value of the systematic bit, the channel value of the systematic bit and the channel value of the parity bit. From these the step forms branch metrics.

The forward port advances the forward metric vector by one step per cycle. Before each update it stores the outgoing vector on an internal last-in first-out stack that holds one sliding window. The backward port advances the backward metric vector by one step per cycle and pops the stack. For every pop it presents three things for a downstream likelihood stage:
- the forward vector that was stored for that step;
- all sixteen branch-plus-next-metric sums;
- a one-cycle valid strobe.

A seed port loads both border vectors, from explicit values or from the cold-start default. Both live vectors are visible at the outputs at all times, so the border metrics of one iteration can be carried into the next. Metrics wrap modulo 2^10 and are compared through the sign of their wrapped difference.

Top module: `trellis_metric_unit`

## Requirements
- R1: After synchronous reset, `alpha_state` and `beta_state` both hold the cold-start vector and `bwd_out_valid` is 0. In the cold-start vector state 0 is 0 and states 1..7 are -256 (10'h300). The stack is empty after reset.
- R2: Trellis state m is packed as {s1,s2,s3} with s1 in bit 2, and the input bit is u. The encoder computes fb = u^s2^s3 and parity p = fb^s1^s3, and moves to next state {fb,s1,s2}. The branch metric for (u,p) is 0 for (0,0), parity for (0,1), a-priori+systematic for (1,0), and a-priori+systematic+parity for (1,1). All inputs are sign-extended to 10 bits.
- R3: A forward step (`fwd_en` without `seed_en`, stack not full) replaces `alpha_state`, visible after that clock edge. For every state n the new value is the larger of the two terms "old forward metric of a predecessor state plus the branch metric that leads into n". Without a forward step or a seed, `alpha_state` does not change.
- R4: A backward step (`bwd_en` without `seed_en`, stack not empty) replaces `beta_state` after that edge. For every state m the new value is the larger of the two terms "branch metric for input j plus old backward metric of the successor state". Without a backward step or a seed, `beta_state` does not change.
- R5: The cycle after a backward step, `bwd_out_valid` is 1 for exactly one cycle. Entry 2*m+j of `bwd_sum` (bits [(2*m+j)*10 +: 10]) holds the branch metric of (m, input j) plus the pre-step backward metric of its successor. `bwd_sum` holds its value when no step occurs.
- R6: Each forward step pushes the pre-step `alpha_state`. Each backward step pops, and `bwd_alpha` shows the entries in the reverse order of their pushes.
- R7: Metric sums wrap modulo 1024. The larger of two candidates a and b is a when bit 9 of (a-b) mod 1024 is 0, and b otherwise.
- R8: `seed_en` loads `alpha_state` from `seed_alpha` and `beta_state` from `seed_beta`. When `seed_dflt` is also 1, it loads the cold-start vector into both instead.
- R9: A cycle with `seed_en` ignores `fwd_en` and `bwd_en`. Nothing is pushed or popped and `bwd_out_valid` stays 0.
- R10: The stack holds WIN entries (default 64). A forward step on a full stack without a backward step is ignored, so `alpha_state` is kept. A backward step on an empty stack is ignored, so `beta_state` is kept and no valid strobe appears.
- R11: A forward and a backward step in the same cycle both happen. The pop returns the entry that was on top before the cycle, the pushed vector takes its place, and the stack depth is unchanged. This also applies when the stack is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_en | input | 1 | Load both border vectors this cycle |
| seed_dflt | input | 1 | With seed_en, load the cold-start vector instead of the seed ports |
| seed_alpha | input | 80 | Forward seed, state m at bits [m*10 +: 10] |
| seed_beta | input | 80 | Backward seed, same packing |
| fwd_en | input | 1 | Forward step request |
| fwd_apri | input | IN_W | Forward step a-priori value, signed |
| fwd_sys | input | IN_W | Forward step systematic channel value, signed |
| fwd_par | input | IN_W | Forward step parity channel value, signed |
| bwd_en | input | 1 | Backward step request |
| bwd_apri | input | IN_W | Backward step a-priori value, signed |
| bwd_sys | input | IN_W | Backward step systematic channel value, signed |
| bwd_par | input | IN_W | Backward step parity channel value, signed |
| alpha_state | output | 80 | Live forward metric vector |
| beta_state | output | 80 | Live backward metric vector |
| bwd_out_valid | output | 1 | Pop result valid |
| bwd_alpha | output | 80 | Forward vector popped for the step just taken backwards |
| bwd_sum | output | 160 | Sixteen branch-plus-next-metric sums, entry 2*m+j |

## Verification
Two functions can fall in the same cycle:
- A forward step and a backward step. This forces a push and a pop onto the one stack together.
- A seed and either step. The seed must suppress the step.

The bench fills the stack with two entries and then raises both step enables in one cycle. It judges the result from three things: the vector popped in that cycle must be the earlier top entry; the following pops must return first the vector pushed in that cycle and then the oldest one; and both metric vectors must follow the reference recursion. It also raises the seed together with both step enables on a non-empty stack. It then confirms that the seeded values appear, that no valid strobe appears, and that the stored entries still pop out intact.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

    localparam int SB  = 3;
    localparam int NST = 1 << SB;
    localparam int M_W = 10;

    typedef logic [M_W-1:0]                  metric_t;
    typedef logic [NST-1:0][M_W-1:0]         mvec_t;
    typedef logic [NST-1:0][1:0][M_W-1:0]    msum_t;

    // the (0,0) branch is always zero and is not carried
    typedef struct packed {
        metric_t g11;
        metric_t g10;
        metric_t g01;
    } gam_t;

    localparam metric_t NEG_INIT = metric_t'(-(1 << (M_W - 2)));

    function automatic mvec_t dflt_vec();
        mvec_t v;
        for (int s = 0; s < NST; s++) begin
            v[s] = (s == 0) ? '0 : NEG_INIT;
        end
        return v;
    endfunction

    // state bits: [2]=newest register, [0]=oldest
    function automatic logic [SB-1:0] nxt_state(logic [SB-1:0] m, logic u);
        logic fb;
        fb = u ^ m[1] ^ m[0];
        return {fb, m[2], m[1]};
    endfunction

    function automatic logic par_bit(logic [SB-1:0] m, logic u);
        logic fb;
        fb = u ^ m[1] ^ m[0];
        return fb ^ m[2] ^ m[0];
    endfunction

    // predecessor of state mn when the input bit is u
    function automatic logic [SB-1:0] prv_state(logic [SB-1:0] mn, logic u);
        return {mn[1], mn[0], mn[2] ^ u ^ mn[0]};
    endfunction

    function automatic metric_t pick_gam(gam_t g, logic u, logic p);
        metric_t r;
        case ({u, p})
            2'b00:   r = '0;
            2'b01:   r = g.g01;
            2'b10:   r = g.g10;
            default: r = g.g11;
        endcase
        return r;
    endfunction

    // modulo max: sign of the wrapped difference decides
    function automatic metric_t wmax(metric_t a, metric_t b);
        metric_t d;
        d = a - b;
        return d[M_W-1] ? b : a;
    endfunction

endpackage

// File: rtl/tmu_branch.sv
module tmu_branch
    import tmu_pkg::*;
#(
    parameter int IN_W = 6
) (
    input  logic signed [IN_W-1:0] apri,
    input  logic signed [IN_W-1:0] sys,
    input  logic signed [IN_W-1:0] par,
    output gam_t                   gam
);
    metric_t ext_a, ext_s, ext_p, sum_as;

    assign ext_a  = metric_t'(apri);
    assign ext_s  = metric_t'(sys);
    assign ext_p  = metric_t'(par);
    assign sum_as = ext_a + ext_s;

    assign gam.g01 = ext_p;
    assign gam.g10 = sum_as;
    assign gam.g11 = sum_as + ext_p;
endmodule

// File: rtl/tmu_alpha_acs.sv
module tmu_alpha_acs
    import tmu_pkg::*;
(
    input  mvec_t cur,
    input  gam_t  gam,
    output mvec_t nxt
);
    for (genvar s = 0; s < NST; s++) begin : g_st
        localparam logic [SB-1:0] P0 = prv_state(SB'(s), 1'b0);
        localparam logic [SB-1:0] P1 = prv_state(SB'(s), 1'b1);
        localparam logic          Q0 = par_bit(P0, 1'b0);
        localparam logic          Q1 = par_bit(P1, 1'b1);
        metric_t c0, c1;
        assign c0     = cur[P0] + pick_gam(gam, 1'b0, Q0);
        assign c1     = cur[P1] + pick_gam(gam, 1'b1, Q1);
        assign nxt[s] = wmax(c0, c1);
    end
endmodule

// File: rtl/tmu_beta_acs.sv
module tmu_beta_acs
    import tmu_pkg::*;
(
    input  mvec_t nxt_b,
    input  gam_t  gam,
    output mvec_t cur_b,
    output msum_t sums
);
    for (genvar s = 0; s < NST; s++) begin : g_st
        localparam logic [SB-1:0] N0 = nxt_state(SB'(s), 1'b0);
        localparam logic [SB-1:0] N1 = nxt_state(SB'(s), 1'b1);
        localparam logic          Q0 = par_bit(SB'(s), 1'b0);
        localparam logic          Q1 = par_bit(SB'(s), 1'b1);
        assign sums[s][0] = pick_gam(gam, 1'b0, Q0) + nxt_b[N0];
        assign sums[s][1] = pick_gam(gam, 1'b1, Q1) + nxt_b[N1];
        assign cur_b[s]   = wmax(sums[s][0], sums[s][1]);
    end
endmodule

// File: rtl/tmu_lifo.sv
module tmu_lifo #(
    parameter int DEPTH = 64,
    parameter int W     = 80,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] top_idx, wr_idx;

    assign top_idx = AW'(level - LW'(1));
    assign wr_idx  = pop ? top_idx : AW'(level);

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_idx] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
            dout  <= '0;
        end else begin
            if (pop) begin
                dout <= mem[top_idx];
            end
            if (push && !pop) begin
                level <= level + LW'(1);
            end else if (pop && !push) begin
                level <= level - LW'(1);
            end
        end
    end
endmodule

// File: rtl/trellis_metric_unit.sv
module trellis_metric_unit
    import tmu_pkg::*;
#(
    parameter int IN_W = 6,
    parameter int WIN  = 64,
    localparam int VW  = NST * M_W,
    localparam int SW  = 2 * VW,
    localparam int LW  = $clog2(WIN + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   seed_en,
    input  logic                   seed_dflt,
    input  logic [VW-1:0]          seed_alpha,
    input  logic [VW-1:0]          seed_beta,
    input  logic                   fwd_en,
    input  logic signed [IN_W-1:0] fwd_apri,
    input  logic signed [IN_W-1:0] fwd_sys,
    input  logic signed [IN_W-1:0] fwd_par,
    input  logic                   bwd_en,
    input  logic signed [IN_W-1:0] bwd_apri,
    input  logic signed [IN_W-1:0] bwd_sys,
    input  logic signed [IN_W-1:0] bwd_par,
    output logic [VW-1:0]          alpha_state,
    output logic [VW-1:0]          beta_state,
    output logic                   bwd_out_valid,
    output logic [VW-1:0]          bwd_alpha,
    output logic [SW-1:0]          bwd_sum
);
    gam_t          gam_f, gam_b;
    mvec_t         alpha_q, beta_q, alpha_d, beta_d, pop_vec;
    msum_t         sums_d, sums_q;
    logic          do_push, do_pop, stk_full, stk_empty;
    logic [LW-1:0] stk_level;

    assign stk_full  = (stk_level == LW'(WIN));
    assign stk_empty = (stk_level == '0);
    assign do_pop    = bwd_en && !seed_en && !stk_empty;
    assign do_push   = fwd_en && !seed_en && (!stk_full || do_pop);

    tmu_branch #(.IN_W(IN_W)) u_gam_f (
        .apri(fwd_apri), .sys(fwd_sys), .par(fwd_par), .gam(gam_f)
    );

    tmu_branch #(.IN_W(IN_W)) u_gam_b (
        .apri(bwd_apri), .sys(bwd_sys), .par(bwd_par), .gam(gam_b)
    );

    tmu_alpha_acs u_alpha (
        .cur(alpha_q), .gam(gam_f), .nxt(alpha_d)
    );

    tmu_beta_acs u_beta (
        .nxt_b(beta_q), .gam(gam_b), .cur_b(beta_d), .sums(sums_d)
    );

    tmu_lifo #(.DEPTH(WIN), .W(VW)) u_stack (
        .clk(clk), .rst(rst), .push(do_push), .pop(do_pop),
        .din(alpha_q), .dout(pop_vec), .level(stk_level)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            alpha_q       <= dflt_vec();
            beta_q        <= dflt_vec();
            sums_q        <= '0;
            bwd_out_valid <= 1'b0;
        end else begin
            bwd_out_valid <= do_pop;
            if (seed_en) begin
                alpha_q <= seed_dflt ? dflt_vec() : mvec_t'(seed_alpha);
                beta_q  <= seed_dflt ? dflt_vec() : mvec_t'(seed_beta);
            end else begin
                if (do_push) begin
                    alpha_q <= alpha_d;
                end
                if (do_pop) begin
                    beta_q <= beta_d;
                    sums_q <= sums_d;
                end
            end
        end
    end

    assign alpha_state = alpha_q;
    assign beta_state  = beta_q;
    assign bwd_alpha   = pop_vec;
    assign bwd_sum     = sums_q;
endmodule

// File: rtl/tmu_checker.sv
module tmu_checker
    import tmu_pkg::*;
#(
    parameter int WIN = 64,
    parameter int LW  = 7
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 seed_en,
    input logic                 seed_dflt,
    input logic [NST*M_W-1:0]   seed_alpha,
    input logic [NST*M_W-1:0]   seed_beta,
    input logic                 fwd_en,
    input logic                 bwd_en,
    input logic [NST*M_W-1:0]   alpha_state,
    input logic [NST*M_W-1:0]   beta_state,
    input logic                 bwd_out_valid,
    input logic [LW-1:0]        stk_level
);
    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst) $past(!rst && seed_en && !seed_dflt) |-> (alpha_state == $past(seed_alpha)) && (beta_state == $past(seed_beta))) else $error("seed load"); // R8
    AST_SEED_COLD: assert property (@(posedge clk) disable iff (rst) $past(!rst && seed_en && seed_dflt) |-> (alpha_state == dflt_vec()) && (beta_state == dflt_vec())) else $error("seed cold"); // R8
    AST_FWD_HOLD: assert property (@(posedge clk) disable iff (rst) $past(!rst && !seed_en && !fwd_en) |-> $stable(alpha_state)) else $error("alpha moved"); // R3
    AST_BWD_HOLD: assert property (@(posedge clk) disable iff (rst) $past(!rst && !seed_en && !bwd_en) |-> $stable(beta_state)) else $error("beta moved"); // R4
    AST_VALID_SRC: assert property (@(posedge clk) disable iff (rst) bwd_out_valid |-> $past(bwd_en && !seed_en)) else $error("stray valid"); // R5
    AST_SEED_WINS: assert property (@(posedge clk) disable iff (rst) $past(!rst && seed_en) |-> !bwd_out_valid && $stable(stk_level)) else $error("step under seed"); // R9
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst) $past(!rst && bwd_en && !seed_en && (stk_level == '0)) |-> !bwd_out_valid && $stable(beta_state)) else $error("pop on empty"); // R10
    AST_FULL_PUSH: assert property (@(posedge clk) disable iff (rst) $past(!rst && fwd_en && !bwd_en && !seed_en && (stk_level == LW'(WIN))) |-> $stable(alpha_state) && (stk_level == LW'(WIN))) else $error("push on full"); // R10
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst) stk_level <= LW'(WIN)) else $error("level range"); // R10
    AST_PAIR_DEPTH: assert property (@(posedge clk) disable iff (rst) $past(!rst && fwd_en && bwd_en && !seed_en && (stk_level != '0)) |-> $stable(stk_level) && bwd_out_valid) else $error("push+pop depth"); // R11
endmodule

bind trellis_metric_unit tmu_checker #(.WIN(WIN), .LW(LW)) u_chk (
    .clk(clk), .rst(rst), .seed_en(seed_en), .seed_dflt(seed_dflt),
    .seed_alpha(seed_alpha), .seed_beta(seed_beta), .fwd_en(fwd_en),
    .bwd_en(bwd_en), .alpha_state(alpha_state), .beta_state(beta_state),
    .bwd_out_valid(bwd_out_valid), .stk_level(stk_level)
);

// File: tb/trellis_metric_unit_tb.sv
module trellis_metric_unit_tb;
    localparam int CLK_P = 10;
    localparam int IN_W  = 6;
    localparam int WIN   = 64;
    localparam int NS    = 8;
    localparam int MW    = 10;
    localparam int VW    = NS * MW;

    typedef logic [NS-1:0][MW-1:0]   vec_t;
    typedef logic [2*NS-1:0][MW-1:0] sum_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic seed_en = 0, seed_dflt = 0, fwd_en = 0, bwd_en = 0;
    logic [VW-1:0] seed_alpha = '0, seed_beta = '0;
    logic signed [IN_W-1:0] fwd_apri = '0, fwd_sys = '0, fwd_par = '0;
    logic signed [IN_W-1:0] bwd_apri = '0, bwd_sys = '0, bwd_par = '0;
    logic [VW-1:0]   alpha_state, beta_state, bwd_alpha;
    logic [2*VW-1:0] bwd_sum;
    logic            bwd_out_valid;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    vec_t m_alpha, m_beta, exp_pop;
    vec_t m_stk [WIN];
    int   m_lvl = 0;
    sum_t exp_sum;
    bit   exp_valid = 0;

    always #(CLK_P/2) clk = ~clk;

    trellis_metric_unit #(.IN_W(IN_W), .WIN(WIN)) u_dut (
        .clk(clk), .rst(rst), .seed_en(seed_en), .seed_dflt(seed_dflt),
        .seed_alpha(seed_alpha), .seed_beta(seed_beta),
        .fwd_en(fwd_en), .fwd_apri(fwd_apri), .fwd_sys(fwd_sys), .fwd_par(fwd_par),
        .bwd_en(bwd_en), .bwd_apri(bwd_apri), .bwd_sys(bwd_sys), .bwd_par(bwd_par),
        .alpha_state(alpha_state), .beta_state(beta_state),
        .bwd_out_valid(bwd_out_valid), .bwd_alpha(bwd_alpha), .bwd_sum(bwd_sum)
    );

    // ---------------- reference model from the requirements ----------------
    function automatic vec_t cold();
        vec_t v;
        for (int s = 0; s < NS; s++) v[s] = (s == 0) ? 10'h000 : 10'h300;
        return v;
    endfunction

    // R2: {next state, parity}
    function automatic logic [3:0] enc(int m, int u);
        logic [2:0] ms;
        logic fb, p;
        ms = 3'(m);
        fb = u[0] ^ ms[1] ^ ms[0];
        p  = fb ^ ms[2] ^ ms[0];
        return {fb, ms[2], ms[1], p};
    endfunction

    function automatic logic [MW-1:0] sx(logic signed [IN_W-1:0] v);
        return MW'(v);
    endfunction

    function automatic logic [MW-1:0] gm(int u, logic p, logic signed [IN_W-1:0] a,
                                         logic signed [IN_W-1:0] s, logic signed [IN_W-1:0] q);
        if (u == 0) return p ? sx(q) : '0;
        return p ? (sx(a) + sx(s) + sx(q)) : (sx(a) + sx(s));
    endfunction

    // R7: x is at least y when the wrapped difference is non-negative
    function automatic bit geq(logic [MW-1:0] x, logic [MW-1:0] y);
        logic [MW-1:0] d;
        d = x - y;
        return !d[MW-1];
    endfunction

    function automatic vec_t f_step(vec_t a, logic signed [IN_W-1:0] ia,
                                    logic signed [IN_W-1:0] is, logic signed [IN_W-1:0] ip);
        vec_t r = '0;
        bit seen [NS];
        for (int s = 0; s < NS; s++) seen[s] = 0;
        for (int m = 0; m < NS; m++) begin
            for (int u = 0; u < 2; u++) begin
                logic [3:0] e;
                logic [MW-1:0] c;
                e = enc(m, u);
                c = a[m] + gm(u, e[0], ia, is, ip);
                if (!seen[e[3:1]] || !geq(r[e[3:1]], c)) begin
                    r[e[3:1]] = c;
                    seen[e[3:1]] = 1;
                end
            end
        end
        return r;
    endfunction

    function automatic sum_t b_sums(vec_t b, logic signed [IN_W-1:0] ia,
                                    logic signed [IN_W-1:0] is, logic signed [IN_W-1:0] ip);
        sum_t r;
        for (int m = 0; m < NS; m++) begin
            for (int u = 0; u < 2; u++) begin
                logic [3:0] e;
                e = enc(m, u);
                r[2*m+u] = gm(u, e[0], ia, is, ip) + b[e[3:1]];
            end
        end
        return r;
    endfunction

    function automatic vec_t b_pick(sum_t sm);
        vec_t r;
        for (int m = 0; m < NS; m++)
            r[m] = geq(sm[2*m], sm[2*m+1]) ? sm[2*m] : sm[2*m+1];
        return r;
    endfunction

    // ---------------- bench plumbing ----------------
    task automatic chk(string tag, logic [2*VW-1:0] act, logic [2*VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // apply the currently driven inputs for one clock, update the model
    task automatic tick();
        bit pop, push;
        if (seed_en) begin
            m_alpha   = seed_dflt ? cold() : vec_t'(seed_alpha);
            m_beta    = seed_dflt ? cold() : vec_t'(seed_beta);
            exp_valid = 0;
        end else begin
            pop  = bwd_en && (m_lvl > 0);
            push = fwd_en && ((m_lvl < WIN) || pop);
            if (pop) begin
                exp_pop = m_stk[m_lvl-1];
                exp_sum = b_sums(m_beta, bwd_apri, bwd_sys, bwd_par);
                m_beta  = b_pick(exp_sum);
            end
            if (push) begin
                if (pop) m_stk[m_lvl-1] = m_alpha;
                else begin
                    m_stk[m_lvl] = m_alpha;
                    m_lvl++;
                end
                m_alpha = f_step(m_alpha, fwd_apri, fwd_sys, fwd_par);
            end else if (pop) begin
                m_lvl--;
            end
            exp_valid = pop;
        end
        @(negedge clk);
        seed_en = 0;
        fwd_en  = 0;
        bwd_en  = 0;
    endtask

    task automatic check_all(string tag);
        chk({tag, " alpha_state"}, alpha_state, m_alpha);
        chk({tag, " beta_state"}, beta_state, m_beta);
        chk({tag, " bwd_out_valid"}, bwd_out_valid, exp_valid);
        if (exp_valid) begin
            chk({tag, " bwd_alpha"}, bwd_alpha, exp_pop);
            chk({tag, " bwd_sum"}, bwd_sum, exp_sum);
        end
    endtask

    task automatic fwd(int a, int s, int p);
        fwd_en = 1; fwd_apri = IN_W'(a); fwd_sys = IN_W'(s); fwd_par = IN_W'(p);
        tick();
    endtask

    task automatic bwd(int a, int s, int p);
        bwd_en = 1; bwd_apri = IN_W'(a); bwd_sys = IN_W'(s); bwd_par = IN_W'(p);
        tick();
    endtask

    task automatic seed(bit dflt, vec_t sa, vec_t sb);
        seed_en = 1; seed_dflt = dflt; seed_alpha = sa; seed_beta = sb;
        tick();
    endtask

    task automatic drain(string tag);
        while (m_lvl > 0) begin
            bwd(1, -1, 2);
            check_all(tag);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        m_alpha = cold();
        m_beta  = cold();
        chk("R1 alpha_state", alpha_state, cold());
        chk("R1 beta_state", beta_state, cold());
        chk("R1 bwd_out_valid", bwd_out_valid, 1'b0);
        bwd(3, 3, 3);   // empty after reset: ignored
        check_all("R1 empty stack");
    endtask

    task automatic t_seed();
        vec_t sa, sb;
        for (int s = 0; s < NS; s++) begin
            sa[s] = MW'(17 * s + 3);
            sb[s] = MW'(1000 - 29 * s);
        end
        seed(0, sa, sb);
        chk("R8 explicit alpha", alpha_state, sa);
        chk("R8 explicit beta", beta_state, sb);
        seed(1, sa, sb);
        chk("R8 cold alpha", alpha_state, cold());
        chk("R8 cold beta", beta_state, cold());
    endtask

    task automatic t_forward();
        seed(1, '0, '0);
        fwd(5, -3, 7);   check_all("R2/R3 step a");
        fwd(-8, 2, -4);  check_all("R2/R3 step b");
        fwd(12, 9, 0);   check_all("R2/R3 step c");
        fwd(0, 0, -15);  check_all("R2/R3 step d");
        fwd(-20, 6, 11); check_all("R3 step e");
        repeat (2) @(negedge clk);
        check_all("R3 idle hold");
    endtask

    task automatic t_backward();
        vec_t sb;
        vec_t keep_a;
        for (int s = 0; s < NS; s++) sb[s] = MW'(40 - 9 * s);
        keep_a = m_alpha;
        seed(0, keep_a, sb);
        bwd(4, 4, -6);   check_all("R4/R5/R6 pop 1");
        chk("R5 valid pulse", bwd_out_valid, 1'b1);
        @(negedge clk);
        chk("R5 valid drops", bwd_out_valid, 1'b0);
        chk("R5 sum held", bwd_sum, exp_sum);
        exp_valid = 0;
        bwd(-7, 1, 9);   check_all("R4/R6 pop 2");
        bwd(10, -10, 3); check_all("R4/R6 pop 3");
        bwd(0, 2, -1);   check_all("R6 pop 4");
        bwd(-3, -3, -3); check_all("R6 pop 5");
    endtask

    task automatic t_wrap();
        vec_t sa;
        for (int s = 0; s < NS; s++) sa[s] = 10'd500;
        seed(0, sa, cold());
        fwd(20, 11, 0);  // 500+31 wraps past +511 and must still win
        chk("R7 wrapped max", alpha_state, {NS{10'd531}});
        check_all("R7 model");
        drain("R7 drain");
    endtask

    task automatic t_collide();
        vec_t sa, sb;
        seed(1, '0, '0);
        fwd(3, 1, -2); fwd(-1, 6, 4);
        check_all("R9 pre");
        for (int s = 0; s < NS; s++) begin
            sa[s] = MW'(5 * s);
            sb[s] = MW'(-7 * s);
        end
        seed_en = 1; seed_dflt = 0; seed_alpha = sa; seed_beta = sb;
        fwd_en = 1; fwd_apri = 9; fwd_sys = 9; fwd_par = 9;
        bwd_en = 1; bwd_apri = 9; bwd_sys = 9; bwd_par = 9;
        tick();
        chk("R9 alpha seeded", alpha_state, sa);
        chk("R9 beta seeded", beta_state, sb);
        chk("R9 no valid", bwd_out_valid, 1'b0);
        drain("R9 stack intact");
    endtask

    task automatic t_both();
        vec_t a0, a1, a2;
        seed(1, '0, '0);
        a0 = m_alpha; fwd(2, 2, 2);
        a1 = m_alpha; fwd(-5, 7, 1);
        a2 = m_alpha;
        fwd_en = 1; fwd_apri = 6; fwd_sys = -2; fwd_par = 5;
        bwd_en = 1; bwd_apri = 1; bwd_sys = 1; bwd_par = -8;
        tick();
        chk("R11 pop returns old top", bwd_alpha, a1);
        check_all("R11 same cycle");
        bwd(0, 3, 3);
        chk("R11 new top", bwd_alpha, a2);
        bwd(0, 3, 3);
        chk("R11 bottom", bwd_alpha, a0);
        check_all("R11 bottom model");
    endtask

    task automatic t_full();
        vec_t hold;
        seed(1, '0, '0);
        for (int i = 0; i < WIN; i++) fwd((i % 7) - 3, (i % 5) - 2, (i % 9) - 4);
        check_all("R10 filled");
        hold = m_alpha;
        fwd(8, 8, 8);
        chk("R10 push on full ignored", alpha_state, hold);
        check_all("R10 full model");
        for (int i = 0; i < WIN; i++) begin
            bwd((i % 4) - 2, (i % 6) - 3, (i % 3) - 1);
            check_all("R6/R10 unwind");
        end
        hold = m_beta;
        bwd(5, 5, 5);
        chk("R10 pop on empty valid", bwd_out_valid, 1'b0);
        chk("R10 pop on empty beta", beta_state, hold);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_seed();
        t_forward();
        t_backward();
        t_wrap();
        t_collide();
        t_both();
        t_full();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule